// File: doc/BRIEF.md
# Byte-Memory DMA Boot Loader

This controller moves words out of a byte-wide external memory and writes them into the processor's internal program or data memory. Software programs an external byte address (split into a page and an in-page offset), an internal word address, a word format, a memory-block overlay and a context-reset flag. It then writes a word count, which starts the copy. Each word is built from one, two or three consecutive bytes, most significant byte first. The internal address and word count registers step as the copy proceeds. A later count write therefore continues from where the previous copy ended.

When reset is released with the boot-mode input high, the controller loads its boot settings on its own and copies the first program block. The settings are offset zero, page zero, internal address zero, 24-bit program words, a count of 32 and context-reset set. It keeps the processor stalled during that copy and then restarts it at address 0. With context-reset clear, the processor keeps executing while a copy runs.

Top module: `bmem_boot_dma`

## Requirements
- R1: Releasing reset with `boot_mode` high starts a copy with no register write. It takes 32 program-memory words from byte addresses 0 to 95 into internal addresses 0 to 31, overlay 0. `core_hold` is high in the first cycle after release.
- R2: Releasing reset with `boot_mode` low starts nothing. All registers reset to zero, so the format is 24-bit program words and context-reset is 0. `busy`, `mem_we` and `core_hold` stay low.
- R3: Format code 0 builds a 24-bit word from three bytes, first byte in bits 23:16, and writes it with `mem_pm` high.
- R4: Format code 1 builds a 16-bit data word from two bytes, first byte in bits 15:8. Code 2 places one byte in bits 15:8 with zero below. Code 3 places one byte in bits 7:0. All three write with `mem_pm` low and bits 23:16 zero.
- R5: One byte is read per cycle. `bm_addr` is the page in its upper bits over the offset. The offset advances by one per byte and wraps to 0 within the page, and the page never changes during a copy.
- R6: Each completed word advances the internal address by one and lowers the count by one. The final offset and internal address are kept, so a new count write continues from them.
- R7: A register write of a nonzero count to select 4 starts a copy. A count of zero starts nothing.
- R8: With context-reset set, `core_hold` is high from the first cycle after the start through the `done` cycle. In the next cycle `core_hold` is low and `core_restart` pulses once.
- R9: With context-reset clear, `core_hold` and `core_restart` stay low during the copy.
- R10: Every write carries the programmed overlay on `mem_ovl`.
- R11: A copy of N words of B bytes each holds `busy` for N*B+2 cycles. `done` pulses once, in the last of those cycles, together with the final `mem_we`.
- R12: Register writes while `busy` is high are ignored.

Register selects for `reg_sel`: 0 internal address, 1 byte offset, 2 page, 3 control (bits 1:0 format, bit 2 context-reset, bits 3 and up overlay), 4 word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_mode | input | 1 | Boot-mode strap, sampled during reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | REG_W (14) | Register write data |
| bm_addr | output | PAGE_W+EXT_AW (22) | Byte-memory address |
| bm_rd | output | 1 | Byte-memory read; data is returned the next cycle |
| bm_rdata | input | 8 | Byte-memory read data |
| mem_we | output | 1 | Internal memory write enable |
| mem_pm | output | 1 | 1 = program memory, 0 = data memory |
| mem_ovl | output | OVL_W (4) | Overlay block select |
| mem_addr | output | INT_AW (14) | Internal word address |
| mem_wdata | output | 24 | Internal write data |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle copy-finished pulse |
| core_hold | output | 1 | Processor stall |
| core_restart | output | 1 | One-cycle restart-at-address-0 pulse |

## Verification
On every cycle the assertions check several properties. Consecutive byte reads step the offset by one and leave the page unchanged. Each completed word lowers the count by one. `done` is a single-cycle pulse. A restart pulse follows `done` by exactly one cycle and has the hold already dropped. Only the bench scenarios can show the rest: word packing and byte order for each format, the boot defaults, continuation across copies, in-page wrap, that zero counts and writes made while busy are ignored, and the exact hold and busy lengths.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
  typedef enum logic [1:0] {
    WT_PM24  = 2'd0,
    WT_DM16  = 2'd1,
    WT_DM8HI = 2'd2,
    WT_DM8LO = 2'd3
  } wtype_e;

  localparam logic [2:0] SEL_INT  = 3'd0;
  localparam logic [2:0] SEL_EXT  = 3'd1;
  localparam logic [2:0] SEL_PAGE = 3'd2;
  localparam logic [2:0] SEL_CTRL = 3'd3;
  localparam logic [2:0] SEL_CNT  = 3'd4;

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/bdma_engine.sv
module bdma_engine
  import bdma_pkg::*;
#(
  parameter int INT_AW     = 14,
  parameter int EXT_AW     = 14,
  parameter int PAGE_W     = 8,
  parameter int CNT_W      = 14,
  parameter int OVL_W      = 4,
  parameter int BOOT_WORDS = 32,
  parameter int REG_W      = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     boot_mode,
  input  logic                     reg_we,
  input  logic [2:0]               reg_sel,
  input  logic [REG_W-1:0]         reg_wdata,
  input  logic                     tail_i,
  output logic                     busy_o,
  output logic                     start_o,
  output logic                     ctx_o,
  output logic [PAGE_W+EXT_AW-1:0] bm_addr,
  output logic                     bm_rd,
  output logic                     rv_o,
  output logic                     rlast_o,
  output logic                     rfinal_o,
  output wtype_e                   rtype_o,
  output logic [INT_AW-1:0]        raddr_o,
  output logic [OVL_W-1:0]         rovl_o
);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_BOOT = CNT_W'(BOOT_WORDS);

  logic [INT_AW-1:0] int_q;
  logic [EXT_AW-1:0] ext_q;
  logic [PAGE_W-1:0] page_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [OVL_W-1:0]  ovl_q;
  wtype_e            type_q;
  logic              ctx_q;
  logic              boot_pend_q;
  logic              run_q;
  logic [1:0]        bidx_q;
  logic [1:0]        nb_m1;
  logic              last_b;
  logic              wr_ok;
  logic              cnt_start;

  always_comb begin
    case (type_q)
      WT_PM24: nb_m1 = 2'd2;
      WT_DM16: nb_m1 = 2'd1;
      default: nb_m1 = 2'd0;
    endcase
  end

  assign last_b    = (bidx_q == nb_m1);
  assign busy_o    = run_q | rv_o | tail_i;
  assign wr_ok     = reg_we & ~busy_o;
  assign cnt_start = wr_ok && (reg_sel == SEL_CNT) && (|reg_wdata[CNT_W-1:0]);
  assign start_o   = boot_pend_q | cnt_start;
  assign ctx_o     = ctx_q;
  assign bm_addr   = {page_q, ext_q};
  assign bm_rd     = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q       <= '0;
      ext_q       <= '0;
      page_q      <= '0;
      ovl_q       <= '0;
      type_q      <= WT_PM24;
      ctx_q       <= boot_mode;
      cnt_q       <= boot_mode ? CNT_BOOT : '0;
      boot_pend_q <= boot_mode;
      run_q       <= 1'b0;
      bidx_q      <= 2'd0;
      rv_o        <= 1'b0;
      rlast_o     <= 1'b0;
      rfinal_o    <= 1'b0;
      rtype_o     <= WT_PM24;
      raddr_o     <= '0;
      rovl_o      <= '0;
    end else begin
      boot_pend_q <= 1'b0;
      rv_o        <= run_q;
      if (wr_ok) begin
        case (reg_sel)
          SEL_INT:  int_q  <= reg_wdata[INT_AW-1:0];
          SEL_EXT:  ext_q  <= reg_wdata[EXT_AW-1:0];
          SEL_PAGE: page_q <= reg_wdata[PAGE_W-1:0];
          SEL_CTRL: begin
            type_q <= wtype_e'(reg_wdata[1:0]);
            ctx_q  <= reg_wdata[2];
            ovl_q  <= reg_wdata[3 +: OVL_W];
          end
          SEL_CNT:  cnt_q  <= reg_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
      if (start_o) begin
        run_q  <= 1'b1;
        bidx_q <= 2'd0;
      end
      if (run_q) begin
        ext_q    <= ext_q + 1'b1;
        rlast_o  <= last_b;
        rfinal_o <= last_b && (cnt_q == CNT_ONE);
        raddr_o  <= int_q;
        rtype_o  <= type_q;
        rovl_o   <= ovl_q;
        if (last_b) begin
          bidx_q <= 2'd0;
          int_q  <= int_q + 1'b1;
          cnt_q  <= cnt_q - 1'b1;
          if (cnt_q == CNT_ONE) run_q <= 1'b0;
        end else begin
          bidx_q <= bidx_q + 1'b1;
        end
      end
    end
  end

  AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (rst)
    (bm_rd && $past(bm_rd)) |-> (bm_addr[EXT_AW-1:0] == $past(bm_addr[EXT_AW-1:0]) + 1'b1)); // R5
  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (rst)
    (bm_rd && $past(bm_rd)) |-> (bm_addr[PAGE_W+EXT_AW-1:EXT_AW] == $past(bm_addr[PAGE_W+EXT_AW-1:EXT_AW]))); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run_q && last_b) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6
endmodule

// File: rtl/bdma_pack.sv
module bdma_pack
  import bdma_pkg::*;
#(
  parameter int INT_AW = 14,
  parameter int OVL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rv_i,
  input  logic              rlast_i,
  input  logic              rfinal_i,
  input  wtype_e            rtype_i,
  input  logic [INT_AW-1:0] raddr_i,
  input  logic [OVL_W-1:0]  rovl_i,
  input  logic [7:0]        bm_rdata,
  output logic              mem_we,
  output logic              mem_pm,
  output logic [OVL_W-1:0]  mem_ovl,
  output logic [INT_AW-1:0] mem_addr,
  output logic [23:0]       mem_wdata,
  output logic              done
);
  logic [15:0] acc_q;
  logic [23:0] word;

  always_comb begin
    case (rtype_i)
      WT_PM24:  word = {acc_q, bm_rdata};
      WT_DM16:  word = {8'h00, acc_q[7:0], bm_rdata};
      WT_DM8HI: word = {8'h00, bm_rdata, 8'h00};
      default:  word = {16'h0000, bm_rdata};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      mem_we    <= 1'b0;
      mem_pm    <= 1'b0;
      mem_ovl   <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      done   <= 1'b0;
      if (rv_i) begin
        acc_q <= {acc_q[7:0], bm_rdata};
        if (rlast_i) begin
          mem_we    <= 1'b1;
          mem_pm    <= (rtype_i == WT_PM24);
          mem_ovl   <= rovl_i;
          mem_addr  <= raddr_i;
          mem_wdata <= word;
          done      <= rfinal_i;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
endmodule

// File: rtl/bdma_hold.sv
module bdma_hold (
  input  logic clk,
  input  logic rst,
  input  logic boot_mode,
  input  logic start_i,
  input  logic ctx_i,
  input  logic done_i,
  output logic core_hold,
  output logic core_restart
);
  always_ff @(posedge clk) begin
    if (rst) begin
      core_hold    <= boot_mode;
      core_restart <= 1'b0;
    end else if (start_i) begin
      core_hold    <= ctx_i;
      core_restart <= 1'b0;
    end else if (done_i && core_hold) begin
      core_hold    <= 1'b0;
      core_restart <= 1'b1;
    end else begin
      core_restart <= 1'b0;
    end
  end

  AST_RESTART_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    core_restart |-> $past(done_i)); // R8
  AST_RESTART_RELEASED: assert property (@(posedge clk) disable iff (rst)
    core_restart |-> (!core_hold && $past(core_hold))); // R8
endmodule

// File: rtl/bmem_boot_dma.sv
module bmem_boot_dma
  import bdma_pkg::*;
#(
  parameter int INT_AW     = 14,
  parameter int EXT_AW     = 14,
  parameter int PAGE_W     = 8,
  parameter int CNT_W      = 14,
  parameter int OVL_W      = 4,
  parameter int BOOT_WORDS = 32,
  localparam int REG_W     = maxi(maxi(INT_AW, EXT_AW), maxi(maxi(PAGE_W, CNT_W), 3 + OVL_W))
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     boot_mode,
  input  logic                     reg_we,
  input  logic [2:0]               reg_sel,
  input  logic [REG_W-1:0]         reg_wdata,
  output logic [PAGE_W+EXT_AW-1:0] bm_addr,
  output logic                     bm_rd,
  input  logic [7:0]               bm_rdata,
  output logic                     mem_we,
  output logic                     mem_pm,
  output logic [OVL_W-1:0]         mem_ovl,
  output logic [INT_AW-1:0]        mem_addr,
  output logic [23:0]              mem_wdata,
  output logic                     busy,
  output logic                     done,
  output logic                     core_hold,
  output logic                     core_restart
);
  logic              start;
  logic              ctx;
  logic              rv;
  logic              rlast;
  logic              rfinal;
  wtype_e            rtype;
  logic [INT_AW-1:0] raddr;
  logic [OVL_W-1:0]  rovl;

  bdma_engine #(
    .INT_AW(INT_AW), .EXT_AW(EXT_AW), .PAGE_W(PAGE_W), .CNT_W(CNT_W),
    .OVL_W(OVL_W), .BOOT_WORDS(BOOT_WORDS), .REG_W(REG_W)
  ) u_engine (
    .clk(clk), .rst(rst), .boot_mode(boot_mode),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .tail_i(done), .busy_o(busy), .start_o(start), .ctx_o(ctx),
    .bm_addr(bm_addr), .bm_rd(bm_rd),
    .rv_o(rv), .rlast_o(rlast), .rfinal_o(rfinal), .rtype_o(rtype),
    .raddr_o(raddr), .rovl_o(rovl)
  );

  bdma_pack #(.INT_AW(INT_AW), .OVL_W(OVL_W)) u_pack (
    .clk(clk), .rst(rst), .rv_i(rv), .rlast_i(rlast), .rfinal_i(rfinal),
    .rtype_i(rtype), .raddr_i(raddr), .rovl_i(rovl), .bm_rdata(bm_rdata),
    .mem_we(mem_we), .mem_pm(mem_pm), .mem_ovl(mem_ovl), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .done(done)
  );

  bdma_hold u_hold (
    .clk(clk), .rst(rst), .boot_mode(boot_mode), .start_i(start),
    .ctx_i(ctx), .done_i(done), .core_hold(core_hold), .core_restart(core_restart)
  );

  AST_WRITE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(busy)); // R11
  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy); // R12
endmodule

// File: tb/bmem_boot_dma_bench.sv
module bmem_boot_dma_bench;
  localparam int INT_AW = 14;
  localparam int EXT_AW = 14;
  localparam int PAGE_W = 8;
  localparam int OVL_W  = 4;
  localparam int REG_W  = 14;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic                     boot_mode = 1'b0;
  logic                     reg_we = 1'b0;
  logic [2:0]               reg_sel = 3'd0;
  logic [REG_W-1:0]         reg_wdata = '0;
  logic [PAGE_W+EXT_AW-1:0] bm_addr;
  logic                     bm_rd;
  logic [7:0]               bm_rdata = 8'h00;
  logic                     mem_we, mem_pm, busy, done, core_hold, core_restart;
  logic [OVL_W-1:0]         mem_ovl;
  logic [INT_AW-1:0]        mem_addr;
  logic [23:0]              mem_wdata;

  bmem_boot_dma u_bmem_boot_dma (
    .clk(clk), .rst(rst), .boot_mode(boot_mode), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .bm_addr(bm_addr), .bm_rd(bm_rd), .bm_rdata(bm_rdata),
    .mem_we(mem_we), .mem_pm(mem_pm), .mem_ovl(mem_ovl), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .done(done), .core_hold(core_hold),
    .core_restart(core_restart)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] bval(input int a);
    return 8'(a * 37 + (a >> 8) * 11 + 3);
  endfunction

  always @(posedge clk) if (bm_rd) bm_rdata <= bval(int'(bm_addr));

  logic [23:0]       lg_data [0:63];
  logic [INT_AW-1:0] lg_addr [0:63];
  logic              lg_pm   [0:63];
  logic [OVL_W-1:0]  lg_ovl  [0:63];
  int n_wr, n_done, n_rs, done_cyc, rs_cyc, last_we_cyc, hold_cyc, busy_cyc, we_nohold, s_cyc;
  bit done_seen;

  always @(negedge clk) begin
    if (mem_we) begin
      if (n_wr < 64) begin
        lg_data[n_wr] = mem_wdata; lg_addr[n_wr] = mem_addr;
        lg_pm[n_wr] = mem_pm; lg_ovl[n_wr] = mem_ovl;
      end
      n_wr++;
      last_we_cyc = cyc;
      if (!core_hold) we_nohold++;
    end
    if (done) begin n_done++; done_cyc = cyc; done_seen = 1; end
    if (core_restart) begin n_rs++; rs_cyc = cyc; end
    if (core_hold) hold_cyc++;
    if (busy) busy_cyc++;
  end

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    total++; bad++;
    $display("FAIL R11 watchdog: cycles %0d expected below 150000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int m_type, m_ctx, m_ovl, m_page, m_ext, m_int;

  task automatic clear_log();
    n_wr = 0; n_done = 0; n_rs = 0; done_cyc = -1; rs_cyc = -1; last_we_cyc = -1;
    hold_cyc = 0; busy_cyc = 0; we_nohold = 0; done_seen = 0;
  endtask

  task automatic wr(input int sel, input int data);
    reg_we = 1'b1; reg_sel = 3'(sel); reg_wdata = REG_W'(data);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_regs(input int ty, input int ctx, input int ovl, input int page, input int ext, input int ia);
    wr(0, ia); wr(1, ext); wr(2, page); wr(3, ty | (ctx << 2) | (ovl << 3));
    m_type = ty; m_ctx = ctx; m_ovl = ovl; m_page = page; m_ext = ext; m_int = ia;
  endtask

  task automatic start_count(input int c);
    clear_log();
    wr(4, c);
    s_cyc = cyc;
  endtask

  task automatic do_reset(input bit bm);
    boot_mode = bm; rst = 1'b1;
    repeat (3) @(negedge clk);
    clear_log();
    rst = 1'b0;
    @(negedge clk);
    s_cyc = cyc;
    m_type = 0; m_ctx = bm; m_ovl = 0; m_page = 0; m_ext = 0; m_int = 0;
  endtask

  task automatic check_xfer(input int c, input string tag, input bit is_boot);
    int nb, t;
    nb = (m_type == 0) ? 3 : (m_type == 1) ? 2 : 1;
    t = 0;
    while (!done_seen && t < 4000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(done_seen, "R11", "done seen", done_seen, 1);
    chk(n_wr == c, tag, "word count", n_wr, c);
    for (int k = 0; k < c && k < 64; k++) begin
      int b [3];
      int ea, w, ia;
      for (int j = 0; j < nb; j++) begin
        ea = (m_ext + k * nb + j) % (1 << EXT_AW);
        b[j] = int'(bval((m_page << EXT_AW) | ea));
      end
      case (m_type)
        0: w = (b[0] << 16) | (b[1] << 8) | b[2];
        1: w = (b[0] << 8) | b[1];
        2: w = b[0] << 8;
        default: w = b[0];
      endcase
      ia = (m_int + k) % (1 << INT_AW);
      chk(lg_data[k] == 24'(w), (m_type == 0) ? "R3" : "R4", "word data", lg_data[k], w);
      chk(lg_addr[k] == INT_AW'(ia), "R6", "internal address", lg_addr[k], ia);
      chk(lg_pm[k] == (m_type == 0), (m_type == 0) ? "R3" : "R4", "memory select", lg_pm[k], m_type == 0);
      chk(lg_ovl[k] == OVL_W'(m_ovl), "R10", "overlay", lg_ovl[k], m_ovl);
    end
    chk(n_done == 1, "R11", "done pulses", n_done, 1);
    chk(done_cyc == s_cyc + c * nb + 1, "R11", "done cycle", done_cyc - s_cyc, c * nb + 1);
    chk(last_we_cyc == done_cyc, "R11", "final write with done", last_we_cyc, done_cyc);
    if (!is_boot) chk(busy_cyc == c * nb + 2, "R11", "busy length", busy_cyc, c * nb + 2);
    if (m_ctx != 0) begin
      chk(we_nohold == 0, "R8", "writes without hold", we_nohold, 0);
      if (!is_boot) chk(hold_cyc == c * nb + 2, "R8", "hold length", hold_cyc, c * nb + 2);
      chk(n_rs == 1, "R8", "restart pulses", n_rs, 1);
      chk(rs_cyc == done_cyc + 1, "R8", "restart cycle", rs_cyc - done_cyc, 1);
      chk(core_hold == 1'b0, "R8", "hold after restart", core_hold, 0);
    end else begin
      chk(hold_cyc == 0, "R9", "hold cycles", hold_cyc, 0);
      chk(n_rs == 0, "R9", "restart pulses", n_rs, 0);
    end
    m_ext = (m_ext + c * nb) % (1 << EXT_AW);
    m_int = (m_int + c) % (1 << INT_AW);
  endtask

  initial begin
    clear_log();
    // R1: boot defaults copy 32 program words with the processor stalled
    do_reset(1'b1);
    chk(core_hold == 1'b1, "R1", "hold after boot release", core_hold, 1);
    chk(busy == 1'b1, "R1", "busy after boot release", busy, 1);
    check_xfer(32, "R1", 1'b1);

    // R2: plain reset starts nothing
    do_reset(1'b0);
    repeat (20) @(negedge clk);
    chk(n_wr == 0, "R2", "writes after plain reset", n_wr, 0);
    chk(busy == 1'b0, "R2", "busy after plain reset", busy, 0);
    chk(hold_cyc == 0, "R2", "hold after plain reset", hold_cyc, 0);
    // R2: reset values give 24-bit program words at address 0, no hold
    start_count(2);
    check_xfer(2, "R2", 1'b0);

    // R3 R4 R9 R10: sweep formats, context-reset and counts
    for (int ty = 0; ty < 4; ty++) begin
      for (int cx = 0; cx < 2; cx++) begin
        for (int ci = 0; ci < 3; ci++) begin
          int c;
          c = (ci == 0) ? 1 : (ci == 1) ? 3 : 7;
          set_regs(ty, cx, (ty * 5 + cx * 3 + ci) % 16, 17 * ty + ci, 100 * ci + 31 * ty + cx,
                   500 * ty + 40 * ci + cx);
          start_count(c);
          check_xfer(c, "R7", 1'b0);
        end
      end
    end

    // R5: offset wraps within the page
    set_regs(0, 1, 9, 200, (1 << EXT_AW) - 2, 77);
    start_count(3);
    check_xfer(3, "R5", 1'b0);

    // R6: a new count continues from the kept offset and internal address
    start_count(4);
    check_xfer(4, "R6", 1'b0);

    // R7: a zero count starts nothing
    clear_log();
    wr(4, 0);
    repeat (10) @(negedge clk);
    chk(n_wr == 0, "R7", "writes after zero count", n_wr, 0);
    chk(busy_cyc == 0, "R7", "busy after zero count", busy_cyc, 0);

    // R12: writes while busy are ignored
    set_regs(0, 0, 3, 5, 60, 300);
    start_count(4);
    wr(4, 50);
    wr(0, 16'h100);
    wr(3, 3 | (1 << 2));
    check_xfer(4, "R12", 1'b0);
    start_count(1);
    check_xfer(1, "R12", 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule